// File: doc/BRIEF.md
# Breakpoint Control Register Access Arbiter

This block sits behind the coprocessor-move decode path of a 32-bit execution state and owns the bank of breakpoint control words. When a move instruction arrives, the block checks whether it addresses this bank. If it does, the block works out what the access may do at the current exception level. There are six possible results. The access may be undefined. It may be diverted to the hypervisor level, through a path for a 64-bit hypervisor or a separate path for a 32-bit hypervisor. It may be diverted to the monitor level. It may halt the core into debug state. Or it may complete.

When the access completes, the block performs it on the selected word. A read returns the stored word and a write stores the source data. Whenever an access is diverted, it also reports the exception class that the exception-entry logic needs. Exception entry itself happens elsewhere.

A request is presented for one cycle. The registered response appears on the next cycle. That response carries a one-hot result, the class code, the read data and one-hot read and write strobes per register.

Top module: `bkpt_acc_arb`

## Requirements
- R1: An access is recognised only when cp_num = 4'hE, op1 = 3'b000, cr_n = 4'h0 and op2 = 3'b101. Any other encoding gives no response: resp_valid stays 0, outcome and both strobe vectors stay 0, and the register bank is left unchanged.
- R2: A recognised request in cycle t produces resp_valid = 1 in cycle t+1. In that cycle outcome is one-hot: bit 0 undefined, bit 1 hypervisor trap (64-bit path), bit 2 hypervisor trap (32-bit path), bit 3 monitor trap, bit 4 halt, bit 5 done.
- R3: A register index cr_m at or above NUM_BKPT gives the undefined result. This check beats every trap and halt condition, and cr_m = NUM_BKPT-1 is still valid.
- R4: Any recognised access with cur_el = 0 is undefined.
- R5: At cur_el = 1 the checks are tried in the following order, and the first one that holds sets the result. If none holds, the access is done.
  - Hypervisor trap (64-bit path): el2_en = 1, el2_aa32 = 0 and hyp64_trap is nonzero.
  - Hypervisor trap (32-bit path): el2_en = 1, el2_aa32 = 1 and hyp32_trap is nonzero.
  - Monitor trap: el3_have = 1, el3_aa32 = 0 and mon_trap = 1.
  - Halt: el1_aa32 = 1, os_lock = 0, halt_ok = 1 and ext_trap = 1.
- R6: At cur_el = 2 the hypervisor trap bits are ignored. The monitor trap check comes first, then the halt check, and otherwise the access is done.
- R7: At cur_el = 3 only the halt check applies; otherwise the access is done.
- R8: syn_class is 6'h05 whenever the result is either hypervisor trap or the monitor trap, and 0 otherwise.
- R9: A done read returns the selected register on rdata and pulses the matching bit of rd_stb.
- R10: A done write stores wdata into the selected register and pulses the matching bit of wr_stb. Any other result writes nothing, so a later done read returns the old value.
- R11: After reset, every register holds 0 and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Move instruction presented this cycle |
| req_write | input | 1 | 1 = write to register, 0 = read |
| cp_num | input | 4 | Coprocessor number field |
| op1 | input | 3 | First opcode field |
| cr_n | input | 4 | Primary register field |
| cr_m | input | 4 | Secondary register field, selects the breakpoint |
| op2 | input | 3 | Second opcode field |
| cur_el | input | 2 | Current exception level |
| el2_en | input | 1 | Hypervisor level enabled |
| el2_aa32 | input | 1 | Hypervisor level runs 32-bit |
| el3_have | input | 1 | Monitor level implemented |
| el3_aa32 | input | 1 | Monitor level runs 32-bit |
| el1_aa32 | input | 1 | Kernel level runs 32-bit |
| hyp64_trap | input | 2 | Debug trap bits of a 64-bit hypervisor |
| hyp32_trap | input | 2 | Debug trap bits of a 32-bit hypervisor |
| mon_trap | input | 1 | Monitor debug-access trap bit |
| os_lock | input | 1 | OS lock set |
| halt_ok | input | 1 | Halting currently permitted |
| ext_trap | input | 1 | External debugger trap bit |
| wdata | input | DATA_W | Source general register for writes |
| resp_valid | output | 1 | Response for previous cycle's request |
| outcome | output | 6 | One-hot result |
| syn_class | output | 6 | Exception class for traps |
| rdata | output | DATA_W | Read data on a done read, else 0 |
| rd_stb | output | NUM_BKPT | One-hot read strobe |
| wr_stb | output | NUM_BKPT | One-hot write strobe |

## Verification
Two functions can meet in one cycle: several trap and halt conditions can be true together with a register write. The bench raises these conditions together, for example a 64-bit hypervisor trap alongside a monitor trap and a halt condition, or a set of traps paired with an out-of-range index. It then judges that only the highest-priority result is reported. A write issued while a trap holds is followed by a done read, which shows through the normal read path that the register kept its old value. The bench also checks that a write pulses only the strobe of the addressed register.

// File: rtl/bkpt_acc_pkg.sv
package bkpt_acc_pkg;

   // positions of the one-hot result bits
   localparam int OC_UNDEF = 0;
   localparam int OC_HYP64 = 1;
   localparam int OC_HYP32 = 2;
   localparam int OC_MON   = 3;
   localparam int OC_HALT  = 4;
   localparam int OC_DONE  = 5;
   localparam int OC_W     = 6;

   localparam logic [5:0] SYN_DBG_TRAP = 6'h05;

   // encoding that selects the breakpoint control bank
   localparam logic [3:0] ENC_CP  = 4'hE;
   localparam logic [2:0] ENC_OP1 = 3'b000;
   localparam logic [3:0] ENC_CRN = 4'h0;
   localparam logic [2:0] ENC_OP2 = 3'b101;

   typedef struct packed {
      logic       el2_en;
      logic       el2_aa32;
      logic       el3_have;
      logic       el3_aa32;
      logic       el1_aa32;
      logic [1:0] hyp64_trap;
      logic [1:0] hyp32_trap;
      logic       mon_trap;
      logic       os_lock;
      logic       halt_ok;
      logic       ext_trap;
   } trap_ctl_t;

endpackage

// File: rtl/bkpt_acc_decode.sv
module bkpt_acc_decode #(
   parameter int NUM_BKPT = 16
) (
   input  logic [3:0] cp_num,
   input  logic [2:0] op1,
   input  logic [3:0] cr_n,
   input  logic [3:0] cr_m,
   input  logic [2:0] op2,
   output logic       hit,
   output logic       idx_ok
);
   import bkpt_acc_pkg::*;

   localparam logic [4:0] LIMIT = 5'(NUM_BKPT);

   assign hit    = (cp_num == ENC_CP) && (op1 == ENC_OP1) &&
                   (cr_n == ENC_CRN) && (op2 == ENC_OP2);
   assign idx_ok = ({1'b0, cr_m} < LIMIT);

endmodule

// File: rtl/bkpt_acc_prio.sv
module bkpt_acc_prio
   import bkpt_acc_pkg::*;
(
   input  logic [1:0]      cur_el,
   input  logic            idx_ok,
   input  trap_ctl_t       ctl,
   output logic [OC_W-1:0] oc
);

   logic hyp64_c, hyp32_c, mon_c, halt_c;

   always_comb begin
      hyp64_c = ctl.el2_en && !ctl.el2_aa32 && (|ctl.hyp64_trap);
      hyp32_c = ctl.el2_en &&  ctl.el2_aa32 && (|ctl.hyp32_trap);
      mon_c   = ctl.el3_have && !ctl.el3_aa32 && ctl.mon_trap;
      halt_c  = ctl.el1_aa32 && !ctl.os_lock && ctl.halt_ok && ctl.ext_trap;
   end

   always_comb begin
      oc = '0;
      if (!idx_ok || cur_el == 2'd0) begin
         oc[OC_UNDEF] = 1'b1;
      end else begin
         unique case (cur_el)
            2'd1: begin
               if      (hyp64_c) oc[OC_HYP64] = 1'b1;
               else if (hyp32_c) oc[OC_HYP32] = 1'b1;
               else if (mon_c)   oc[OC_MON]   = 1'b1;
               else if (halt_c)  oc[OC_HALT]  = 1'b1;
               else              oc[OC_DONE]  = 1'b1;
            end
            2'd2: begin
               if      (mon_c)   oc[OC_MON]   = 1'b1;
               else if (halt_c)  oc[OC_HALT]  = 1'b1;
               else              oc[OC_DONE]  = 1'b1;
            end
            default: begin
               if (halt_c) oc[OC_HALT] = 1'b1;
               else        oc[OC_DONE] = 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/bkpt_acc_bank.sv
module bkpt_acc_bank #(
   parameter int NUM_BKPT = 16,
   parameter int DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        sel,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] regs [NUM_BKPT];

   for (genvar i = 0; i < NUM_BKPT; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              regs[i] <= '0;
         else if (wr_en && (sel == 4'(i)))        regs[i] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int j = 0; j < NUM_BKPT; j++) begin
         if (sel == 4'(j)) rdata = regs[j];
      end
   end

endmodule

// File: rtl/bkpt_acc_arb.sv
module bkpt_acc_arb #(
   parameter int NUM_BKPT = 16,
   parameter int DATA_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [3:0]          cp_num,
   input  logic [2:0]          op1,
   input  logic [3:0]          cr_n,
   input  logic [3:0]          cr_m,
   input  logic [2:0]          op2,
   input  logic [1:0]          cur_el,
   input  logic                el2_en,
   input  logic                el2_aa32,
   input  logic                el3_have,
   input  logic                el3_aa32,
   input  logic                el1_aa32,
   input  logic [1:0]          hyp64_trap,
   input  logic [1:0]          hyp32_trap,
   input  logic                mon_trap,
   input  logic                os_lock,
   input  logic                halt_ok,
   input  logic                ext_trap,
   input  logic [DATA_W-1:0]   wdata,
   output logic                resp_valid,
   output logic [5:0]          outcome,
   output logic [5:0]          syn_class,
   output logic [DATA_W-1:0]   rdata,
   output logic [NUM_BKPT-1:0] rd_stb,
   output logic [NUM_BKPT-1:0] wr_stb
);
   import bkpt_acc_pkg::*;

   if (NUM_BKPT < 1 || NUM_BKPT > 16) begin : g_bad_num
      $error("NUM_BKPT must lie in 1..16");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic            hit, idx_ok, fire, done_wr, done_rd;
   logic [OC_W-1:0] oc;
   logic [DATA_W-1:0] bank_rd;
   logic [NUM_BKPT-1:0] sel_vec;
   trap_ctl_t       ctl;

   assign ctl = '{el2_en: el2_en, el2_aa32: el2_aa32, el3_have: el3_have,
                  el3_aa32: el3_aa32, el1_aa32: el1_aa32,
                  hyp64_trap: hyp64_trap, hyp32_trap: hyp32_trap,
                  mon_trap: mon_trap, os_lock: os_lock, halt_ok: halt_ok,
                  ext_trap: ext_trap};

   bkpt_acc_decode #(.NUM_BKPT(NUM_BKPT)) u_dec (
      .cp_num(cp_num), .op1(op1), .cr_n(cr_n), .cr_m(cr_m), .op2(op2),
      .hit(hit), .idx_ok(idx_ok)
   );

   bkpt_acc_prio u_prio (
      .cur_el(cur_el), .idx_ok(idx_ok), .ctl(ctl), .oc(oc)
   );

   assign fire    = req_valid && hit;
   assign done_wr = fire && oc[OC_DONE] && req_write;
   assign done_rd = fire && oc[OC_DONE] && !req_write;

   bkpt_acc_bank #(.NUM_BKPT(NUM_BKPT), .DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .sel(cr_m), .wr_en(done_wr),
      .wdata(wdata), .rdata(bank_rd)
   );

   for (genvar i = 0; i < NUM_BKPT; i++) begin : g_sel
      assign sel_vec[i] = (cr_m == 4'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         outcome    <= '0;
         syn_class  <= '0;
         rdata      <= '0;
         rd_stb     <= '0;
         wr_stb     <= '0;
      end else begin
         resp_valid <= fire;
         outcome    <= fire ? oc : '0;
         syn_class  <= (fire && (oc[OC_HYP64] || oc[OC_HYP32] || oc[OC_MON]))
                       ? SYN_DBG_TRAP : '0;
         rdata      <= done_rd ? bank_rd : '0;
         rd_stb     <= done_rd ? sel_vec : '0;
         wr_stb     <= done_wr ? sel_vec : '0;
      end
   end

endmodule

// File: rtl/bkpt_acc_chk.sv
module bkpt_acc_chk #(
   parameter int NUM_BKPT = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic [3:0]          cp_num,
   input logic [2:0]          op1,
   input logic [3:0]          cr_n,
   input logic [2:0]          op2,
   input logic [1:0]          cur_el,
   input logic                resp_valid,
   input logic [5:0]          outcome,
   input logic [5:0]          syn_class,
   input logic [NUM_BKPT-1:0] rd_stb,
   input logic [NUM_BKPT-1:0] wr_stb
);

   logic enc_hit;
   assign enc_hit = req_valid && cp_num == 4'hE && op1 == 3'b000 &&
                    cr_n == 4'h0 && op2 == 3'b101;

   // R2
   resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enc_hit |=> resp_valid);

   // R2
   outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> $onehot(outcome));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_valid |-> (outcome == 6'd0 && rd_stb == '0 && wr_stb == '0));

   // R4
   el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_hit && cur_el == 2'd0) |=> outcome == 6'b000001);

   // R8
   trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|outcome[3:1]) |-> syn_class == 6'h05);

   // R8
   no_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|outcome[3:1]) |-> syn_class == 6'h00);

   // R10
   wr_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb != '0) |-> (outcome[5] && $onehot(wr_stb) && rd_stb == '0));

   // R9
   rd_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb != '0) |-> (outcome[5] && $onehot(rd_stb)));

endmodule

bind bkpt_acc_arb bkpt_acc_chk #(.NUM_BKPT(NUM_BKPT)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cp_num(cp_num),
   .op1(op1), .cr_n(cr_n), .op2(op2), .cur_el(cur_el),
   .resp_valid(resp_valid), .outcome(outcome), .syn_class(syn_class),
   .rd_stb(rd_stb), .wr_stb(wr_stb)
);

// File: tb/bkpt_acc_arb_tb_top.sv
module bkpt_acc_arb_tb_top;

   localparam int NB = 12;
   localparam int DW = 32;
   localparam logic [5:0] U = 6'h01, H64 = 6'h02, H32 = 6'h04, M = 6'h08,
                          HLT = 6'h10, D = 6'h20;

   typedef struct packed {
      logic [1:0] el;
      logic       e2en, e2_32;
      logic [1:0] h64, h32;
      logic       e3p, e3_32, mtr, e1_32, oslk, hok, edt;
      logic [3:0] crm;
      logic [5:0] exp;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{2'd0,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2,U},
      '{2'd1,1'b1,1'b0,2'b01,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2,H64},
      '{2'd1,1'b1,1'b0,2'b10,2'b00,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd2,H64},
      '{2'd1,1'b1,1'b1,2'b11,2'b01,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd2,H32},
      '{2'd1,1'b0,1'b0,2'b11,2'b11,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd2,M},
      '{2'd1,1'b0,1'b0,2'b00,2'b00,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'd2,HLT},
      '{2'd1,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,4'd2,D},
      '{2'd1,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,4'd2,D},
      '{2'd2,1'b1,1'b0,2'b11,2'b11,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2,D},
      '{2'd2,1'b0,1'b0,2'b00,2'b00,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'd2,M},
      '{2'd3,1'b0,1'b0,2'b00,2'b00,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd2,D},
      '{2'd3,1'b0,1'b0,2'b00,2'b00,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'd2,HLT},
      '{2'd1,1'b1,1'b0,2'b11,2'b00,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'd12,U},
      '{2'd0,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd15,U},
      '{2'd1,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd11,D}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [3:0] cp_num = 4'hE, cr_n = 4'h0, cr_m = 4'h0;
   logic [2:0] op1 = 3'b000, op2 = 3'b101;
   logic [1:0] cur_el = 2'd1;
   logic el2_en = 0, el2_aa32 = 0, el3_have = 0, el3_aa32 = 0, el1_aa32 = 0;
   logic [1:0] hyp64_trap = 0, hyp32_trap = 0;
   logic mon_trap = 0, os_lock = 0, halt_ok = 0, ext_trap = 0;
   logic [DW-1:0] wdata = '0;
   logic resp_valid;
   logic [5:0] outcome, syn_class;
   logic [DW-1:0] rdata;
   logic [NB-1:0] rd_stb, wr_stb;

   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   bkpt_acc_arb #(.NUM_BKPT(NB), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .cp_num(cp_num), .op1(op1), .cr_n(cr_n), .cr_m(cr_m), .op2(op2),
      .cur_el(cur_el), .el2_en(el2_en), .el2_aa32(el2_aa32),
      .el3_have(el3_have), .el3_aa32(el3_aa32), .el1_aa32(el1_aa32),
      .hyp64_trap(hyp64_trap), .hyp32_trap(hyp32_trap), .mon_trap(mon_trap),
      .os_lock(os_lock), .halt_ok(halt_ok), .ext_trap(ext_trap),
      .wdata(wdata), .resp_valid(resp_valid), .outcome(outcome),
      .syn_class(syn_class), .rdata(rdata), .rd_stb(rd_stb), .wr_stb(wr_stb)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic set_ctl(input vec_t v);
      cur_el = v.el; el2_en = v.e2en; el2_aa32 = v.e2_32;
      hyp64_trap = v.h64; hyp32_trap = v.h32; el3_have = v.e3p;
      el3_aa32 = v.e3_32; mon_trap = v.mtr; el1_aa32 = v.e1_32;
      os_lock = v.oslk; halt_ok = v.hok; ext_trap = v.edt; cr_m = v.crm;
   endtask

   // one request; response sampled at the next falling edge
   task automatic access(input logic wr, input logic [DW-1:0] d);
      req_write = wr; wdata = d; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   function automatic string req_of(input vec_t v);
      if (v.crm >= 4'(NB)) return "R3";
      case (v.el)
         2'd0: return "R4";
         2'd1: return "R5";
         2'd2: return "R6";
         default: return "R7";
      endcase
   endfunction

   vec_t quiet;

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      quiet = '{2'd1,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,D};
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11", "resp_valid", {31'd0, resp_valid}, 32'd0);
      chk("R11", "outcome", {26'd0, outcome}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      quiet.crm = 4'd3; set_ctl(quiet);
      access(1'b0, '0);
      chk("R11", "read after reset", rdata, 32'd0);

      // table walk: priority chains and out-of-range index
      for (int i = 0; i < NV; i++) begin
         set_ctl(VECS[i]);
         access(1'b0, '0);
         chk(req_of(VECS[i]), $sformatf("vec %0d outcome", i),
             {26'd0, outcome}, {26'd0, VECS[i].exp});
         chk("R2", $sformatf("vec %0d valid", i), {31'd0, resp_valid}, 32'd1);
         chk("R8", $sformatf("vec %0d class", i), {26'd0, syn_class},
             (VECS[i].exp inside {H64, H32, M}) ? 32'h5 : 32'h0);
      end

      // R10 done write then R9 read back
      quiet.crm = 4'd5; set_ctl(quiet);
      access(1'b1, 32'hA5A5_1234);
      chk("R10", "wr_stb", {20'd0, wr_stb}, 32'h020);
      chk("R10", "outcome", {26'd0, outcome}, {26'd0, D});
      access(1'b0, '0);
      chk("R9", "rdata", rdata, 32'hA5A5_1234);
      chk("R9", "rd_stb", {20'd0, rd_stb}, 32'h020);

      // R10 trapped write leaves register unchanged
      el2_en = 1'b1; hyp64_trap = 2'b01; el3_have = 1'b1; mon_trap = 1'b1;
      access(1'b1, 32'h0BAD_0BAD);
      chk("R10", "trapped outcome", {26'd0, outcome}, {26'd0, H64});
      chk("R10", "trapped wr_stb", {20'd0, wr_stb}, 32'd0);
      set_ctl(quiet);
      access(1'b0, '0);
      chk("R10", "value kept", rdata, 32'hA5A5_1234);

      // R1 unrecognised encoding: no response, no write
      op2 = 3'b100;
      access(1'b1, 32'h1111_2222);
      chk("R1", "resp_valid", {31'd0, resp_valid}, 32'd0);
      chk("R1", "wr_stb", {20'd0, wr_stb}, 32'd0);
      op2 = 3'b101; cp_num = 4'hF;
      access(1'b1, 32'h3333_4444);
      chk("R1", "outcome", {26'd0, outcome}, 32'd0);
      cp_num = 4'hE;
      access(1'b0, '0);
      chk("R1", "bank untouched", rdata, 32'hA5A5_1234);

      // R3 highest valid index writes and reads
      quiet.crm = 4'(NB - 1); set_ctl(quiet);
      access(1'b1, 32'hCAFE_0011);
      access(1'b0, '0);
      chk("R3", "last index read", rdata, 32'hCAFE_0011);

      // R4 write at EL0 has no effect
      cur_el = 2'd0;
      access(1'b1, 32'h0);
      chk("R4", "el0 write", {26'd0, outcome}, {26'd0, U});
      cur_el = 2'd1;
      access(1'b0, '0);
      chk("R4", "el0 write ignored", rdata, 32'hCAFE_0011);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule